// File: doc/BRIEF.md
# Eight-Channel Down-Counter Register Block

This block puts eight down-counting timer channels behind a single 32-bit word-addressed register port. Each channel has its own 16-byte window holding a live count, a reload value and two match values. The address map is split: three windows sit below a shared control word and five sit above it. The shared control word packs a 4-bit field for each channel. When a control write changes a field, the channel's configuration bits take effect at once. A newly set enable reaches the counter one clock later, so a channel never starts counting under its old configuration.

Each channel counts down on every clock, or on an external tick strobe, and reloads when it passes zero. It pulses its own interrupt line when the count lands on either match value, or on zero with the zero interrupt enabled. The upper four channels also offer a one-shot mode that parks the count at zero. Software reaches all of this through plain reads and writes. Read data returns one cycle after the request. Bad accesses raise a one-cycle error flag.

Top module: `tmr_bank`

## Requirements
- R1: Channel windows are 16 bytes. Windows at 0x00, 0x10 and 0x20 are channels 0 to 2, and windows at 0x40 to 0x80 are channels 3 to 7 (index = offset/16 - 1). Inside a window, +0x0 is the count, +0x4 the reload, +0x8 match A and +0xC match B. Reload and match registers read back what was written.
- R2: The control word at 0x30 holds a 4-bit field for channel i at bits 4i+3..4i: bit 0 enable, bit 1 external-tick select, bit 2 zero-interrupt enable, bit 3 one-shot. It reads back as written. Offset 0x34 is a plain 32-bit scratch word that reads back as written.
- R3: An access is bad if its offset is 0x38 or 0x3C, is at or above 0x90, or has address bits [1:0] nonzero. A bad read returns 0, a bad write changes nothing, and err_o is high for exactly the cycle after any bad access. A legal access leaves err_o low.
- R4: After reset, the control and scratch words, all reload, match and count registers, and all irq_o lines are zero.
- R5: When a control write sets a channel's enable, its other bits apply from that write edge and the first count step happens on the second clock edge after the write.
- R6: When a control write clears a channel's enable, no count step happens after that write edge, and the count holds.
- R7: An enabled channel steps once per clock when its tick select is 0, or once per clock with ext_tick_i[i] high when the select is 1. A step decrements the count, or loads the reload value when the count is 0.
- R8: A write to a channel's count register loads the written value at that edge if the channel's enable bit is set, and is ignored otherwise.
- R9: irq_o[i] is high for one cycle, updating on the same edge as the count, when a step takes a nonzero count to a value equal to match A or match B, or to zero with the zero-interrupt enable set. A step from zero never pulses.
- R10: On channels 4 to 7 with one-shot set, a step at count 0 leaves the count at 0 and raises no interrupt.
- R11: On channels 0 to 3 the one-shot bit is stored but ignored (the step at zero reloads). A control write setting any of those four bits raises err_o.
- R12: rdata_o is registered. It is valid the cycle after a read, and a count read returns the count held just before the read's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Access request this cycle |
| wr_i | input | 1 | 1 write, 0 read |
| addr_i | input | ADDR_W | Byte offset of the access |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after the read |
| err_o | output | 1 | Bad access flag, one cycle after the access |
| ext_tick_i | input | 8 | Per-channel external count strobe |
| irq_o | output | 8 | Per-channel interrupt pulse |

## Verification
A wrong enable-delay state shows as a count read that shifts by one position in a run of back-to-back reads taken right after the enabling write. A stale one-shot or match decode shows at the very next external tick, as a missing or extra irq_o pulse or as a count that reloads instead of parking. A decode slip in the split map shows at once, because a register read back from a neighbouring window, or from the control hole, has the wrong value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned N_CHAN        = 8;
  localparam int unsigned CTRL_W        = 4;
  localparam int unsigned FIRST_ONESHOT = 4;
  localparam int unsigned CTRL_TOT      = N_CHAN * CTRL_W;

  typedef struct packed {
    logic oneshot;
    logic zero_ie;
    logic ext_sel;
    logic en;
  } chan_cfg_t;

  typedef enum logic [1:0] {
    REG_CNT    = 2'd0,
    REG_RELOAD = 2'd1,
    REG_MA     = 2'd2,
    REG_MB     = 2'd3
  } chan_reg_e;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int unsigned W          = 32,
  parameter bit          ONESHOT_OK = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ext_sel_i,
  input  logic         ext_tick_i,
  input  logic         zero_ie_i,
  input  logic         oneshot_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] reload_i,
  input  logic [W-1:0] match_a_i,
  input  logic [W-1:0] match_b_i,
  output logic [W-1:0] cnt_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q, cnt_dec;
  logic step, hit, os_eff, at_zero;

  assign os_eff  = ONESHOT_OK ? oneshot_i : 1'b0;
  assign step    = en_i & (ext_sel_i ? ext_tick_i : 1'b1);
  assign at_zero = (cnt_q == '0);
  assign cnt_dec = cnt_q - W'(1);
  assign hit     = !at_zero & ((cnt_dec == match_a_i) | (cnt_dec == match_b_i) |
                               ((cnt_dec == '0) & zero_ie_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= step & hit & ~load_i;
      if (load_i)       cnt_q <= load_val_i;
      else if (step)    cnt_q <= at_zero ? (os_eff ? '0 : reload_i) : cnt_dec;
    end
  end

  assign cnt_o = cnt_q;

  // R6
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_o));

  // R10
  oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && os_eff && at_zero && !load_i) |=> (cnt_o == '0) && !irq_o);

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_i));
endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
  import tmr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CTRL_TOT-1:0] ctrl_i,
  output logic [N_CHAN-1:0]   en_o,
  output logic [N_CHAN-1:0]   ext_sel_o,
  output logic [N_CHAN-1:0]   zero_ie_o,
  output logic [N_CHAN-1:0]   oneshot_o
);
  logic [N_CHAN-1:0] en_dly_q;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_ch
    chan_cfg_t cfg;
    assign cfg          = chan_cfg_t'(ctrl_i[g*CTRL_W +: CTRL_W]);
    // rise lags the field by one clock, fall follows it at once
    assign en_o[g]      = cfg.en & en_dly_q[g];
    assign ext_sel_o[g] = cfg.ext_sel;
    assign zero_ie_o[g] = cfg.zero_ie;
    assign oneshot_o[g] = cfg.oneshot;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_dly_q[g] <= 1'b0;
      else         en_dly_q[g] <= cfg.en;
    end

    // R5
    en_after_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en_o[g]) |-> $past(ctrl_i[g*CTRL_W]));
  end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                err_o,
  input  logic [DATA_W-1:0]   cnt_i    [N_CHAN],
  output logic [DATA_W-1:0]   reload_o [N_CHAN],
  output logic [DATA_W-1:0]   ma_o     [N_CHAN],
  output logic [DATA_W-1:0]   mb_o     [N_CHAN],
  output logic [N_CHAN-1:0]   load_o,
  output logic [CTRL_TOT-1:0] ctrl_o
);
  localparam int unsigned IDX_W    = $clog2(N_CHAN);
  localparam logic [7:0]  CTRL_OFF = 8'h30;
  localparam logic [7:0]  AUX_OFF  = 8'h34;
  localparam logic [7:0]  HOLE_END = 8'h40;
  localparam logic [7:0]  MAP_END  = 8'h90;

  logic [7:0]        off;
  logic              hi_zero, aligned, lo_grp, hi_grp;
  logic              ch_hit, ctrl_hit, aux_hit, bad, os_err, wr_ch;
  logic [IDX_W-1:0]  ch_idx;
  chan_reg_e         reg_sel;
  logic [DATA_W-1:0] aux_q, rd_nxt;
  logic [CTRL_TOT-1:0] ctrl_q;

  assign off      = addr_i[7:0];
  assign hi_zero  = (addr_i[ADDR_W-1:8] == '0);
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign lo_grp   = (off < CTRL_OFF);
  assign hi_grp   = (off >= HOLE_END) && (off < MAP_END);
  assign ch_hit   = hi_zero & aligned & (lo_grp | hi_grp);
  assign ctrl_hit = hi_zero & (off == CTRL_OFF);
  assign aux_hit  = hi_zero & (off == AUX_OFF);
  assign bad      = !(ch_hit | ctrl_hit | aux_hit);
  assign ch_idx   = lo_grp ? IDX_W'(off[5:4]) : IDX_W'(off[7:4] - 4'd1);
  assign reg_sel  = chan_reg_e'(off[3:2]);
  assign wr_ch    = sel_i & wr_i & ch_hit;

  always_comb begin
    os_err = 1'b0;
    for (int i = 0; i < int'(FIRST_ONESHOT); i++) os_err |= wdata_i[i*CTRL_W+3];
  end

  for (genvar g = 0; g < N_CHAN; g++) begin : g_ld
    assign load_o[g] = wr_ch && (ch_idx == IDX_W'(g)) && (reg_sel == REG_CNT) &&
                       ctrl_q[g*CTRL_W];
  end

  always_comb begin
    rd_nxt = '0;
    if (ctrl_hit)     rd_nxt = DATA_W'(ctrl_q);
    else if (aux_hit) rd_nxt = aux_q;
    else if (ch_hit) begin
      unique case (reg_sel)
        REG_CNT:    rd_nxt = cnt_i[ch_idx];
        REG_RELOAD: rd_nxt = reload_o[ch_idx];
        REG_MA:     rd_nxt = ma_o[ch_idx];
        REG_MB:     rd_nxt = mb_o[ch_idx];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      aux_q   <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
      for (int i = 0; i < int'(N_CHAN); i++) begin
        reload_o[i] <= '0;
        ma_o[i]     <= '0;
        mb_o[i]     <= '0;
      end
    end else begin
      rdata_o <= (sel_i && !wr_i) ? rd_nxt : '0;
      err_o   <= sel_i & (bad | (wr_i & ctrl_hit & os_err));
      if (sel_i && wr_i && ctrl_hit) ctrl_q <= wdata_i[CTRL_TOT-1:0];
      if (sel_i && wr_i && aux_hit)  aux_q  <= wdata_i;
      for (int i = 0; i < int'(N_CHAN); i++) begin
        if (wr_ch && ch_idx == IDX_W'(i)) begin
          case (reg_sel)
            REG_RELOAD: reload_o[i] <= wdata_i;
            REG_MA:     ma_o[i]     <= wdata_i;
            REG_MB:     mb_o[i]     <= wdata_i;
            default:    ;
          endcase
        end
      end
    end
  end

  assign ctrl_o = ctrl_q;

  // R3
  bad_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && bad) |=> ($stable(ctrl_o) && $stable(aux_q)));

  // R3
  bad_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && bad) |=> (err_o && rdata_o == '0));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic [N_CHAN-1:0] ext_tick_i,
  output logic [N_CHAN-1:0] irq_o
);
  logic [DATA_W-1:0]   cnt_w [N_CHAN];
  logic [DATA_W-1:0]   rel_w [N_CHAN];
  logic [DATA_W-1:0]   ma_w  [N_CHAN];
  logic [DATA_W-1:0]   mb_w  [N_CHAN];
  logic [N_CHAN-1:0]   load_w, en_w, ext_w, zie_w, os_w;
  logic [CTRL_TOT-1:0] ctrl_w;

  tmr_regif #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk_i, .rst_ni, .sel_i, .wr_i, .addr_i, .wdata_i, .rdata_o, .err_o,
    .cnt_i(cnt_w), .reload_o(rel_w), .ma_o(ma_w), .mb_o(mb_w),
    .load_o(load_w), .ctrl_o(ctrl_w)
  );

  tmr_ctrl_seq u_seq (
    .clk_i, .rst_ni, .ctrl_i(ctrl_w),
    .en_o(en_w), .ext_sel_o(ext_w), .zero_ie_o(zie_w), .oneshot_o(os_w)
  );

  for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
    tmr_chan #(.W(DATA_W), .ONESHOT_OK(g >= int'(FIRST_ONESHOT))) u_chan (
      .clk_i, .rst_ni,
      .en_i(en_w[g]), .ext_sel_i(ext_w[g]), .ext_tick_i(ext_tick_i[g]),
      .zero_ie_i(zie_w[g]), .oneshot_i(os_w[g]),
      .load_i(load_w[g]), .load_val_i(wdata_i),
      .reload_i(rel_w[g]), .match_a_i(ma_w[g]), .match_b_i(mb_w[g]),
      .cnt_o(cnt_w[g]), .irq_o(irq_o[g])
    );
  end
endmodule

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [7:0]  ext_tick = '0;
  logic [7:0]  irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tmr_bank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .ext_tick_i(ext_tick), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] start;
    logic [31:0] ma;
    logic [31:0] mb;
    logic        zie;
    logic        os;
    logic        irq;
    logic [31:0] cnt;
  } vec_t;

  // channel 5, reload 50, external tick; one tick per row
  localparam vec_t VECS [9] = '{
    '{32'd9, 32'd4, 32'd7, 1'b0, 1'b0, 1'b0, 32'd8},
    '{32'd8, 32'd7, 32'd4, 1'b0, 1'b0, 1'b1, 32'd7},
    '{32'd5, 32'd9, 32'd4, 1'b0, 1'b0, 1'b1, 32'd4},
    '{32'd1, 32'd3, 32'd2, 1'b0, 1'b0, 1'b0, 32'd0},
    '{32'd1, 32'd3, 32'd2, 1'b1, 1'b0, 1'b1, 32'd0},
    '{32'd1, 32'd0, 32'd6, 1'b0, 1'b0, 1'b1, 32'd0},
    '{32'd0, 32'd3, 32'd2, 1'b1, 1'b0, 1'b0, 32'd50},
    '{32'd0, 32'd3, 32'd2, 1'b0, 1'b1, 1'b0, 32'd0},
    '{32'd2, 32'd3, 32'd1, 1'b0, 1'b1, 1'b1, 32'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the response
  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] r, output logic e);
    sel = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    r = rdata; e = err;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r; logic e;
    bus(1'b1, a, d, r, e);
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] r);
    logic e;
    bus(1'b0, a, '0, r, e);
  endtask

  task automatic tick(input int c, output logic irq_seen);
    ext_tick[c] = 1'b1;
    @(negedge clk);
    irq_seen = irq[c];
    ext_tick[c] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r, r2;
    logic e, iq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R4 reset state
    chk("R4 irq after reset", {24'd0, irq}, 32'd0);
    rd_reg(12'h030, r); chk("R4 ctrl reset", r, 32'd0);
    rd_reg(12'h034, r); chk("R4 scratch reset", r, 32'd0);
    rd_reg(12'h04C, r); chk("R4 match B ch3 reset", r, 32'd0);
    rd_reg(12'h084, r); chk("R4 reload ch7 reset", r, 32'd0);
    rd_reg(12'h000, r); chk("R4 count ch0 reset", r, 32'd0);

    // R1 split map readback
    wr_reg(12'h024, 32'd111);
    wr_reg(12'h044, 32'd222);
    wr_reg(12'h028, 32'hA5A5_0001);
    wr_reg(12'h08C, 32'h1234_5678);
    rd_reg(12'h024, r); chk("R1 reload ch2", r, 32'd111);
    rd_reg(12'h044, r); chk("R1 reload ch3", r, 32'd222);
    rd_reg(12'h028, r); chk("R1 match A ch2", r, 32'hA5A5_0001);
    rd_reg(12'h08C, r); chk("R1 match B ch7", r, 32'h1234_5678);
    rd_reg(12'h02C, r); chk("R1 match B ch2 untouched", r, 32'd0);

    // R2 scratch word
    wr_reg(12'h034, 32'hDEAD_BEEF);
    rd_reg(12'h034, r); chk("R2 scratch readback", r, 32'hDEAD_BEEF);

    // R3 bad accesses
    bus(1'b0, 12'h038, '0, r, e);
    chk("R3 read 0x38 data", r, 32'd0); chk("R3 read 0x38 err", {31'd0, e}, 32'd1);
    bus(1'b1, 12'h03C, 32'hFFFF_FFFF, r, e);
    chk("R3 write 0x3C err", {31'd0, e}, 32'd1);
    bus(1'b1, 12'h031, 32'hFFFF_FFFF, r, e);
    chk("R3 misaligned err", {31'd0, e}, 32'd1);
    bus(1'b0, 12'h090, '0, r, e);
    chk("R3 past map err", {31'd0, e}, 32'd1);
    bus(1'b1, 12'h130, 32'hFFFF_FFFF, r, e);
    chk("R3 high address err", {31'd0, e}, 32'd1);
    bus(1'b0, 12'h034, '0, r, e);
    chk("R3 scratch unchanged", r, 32'hDEAD_BEEF); chk("R3 legal no err", {31'd0, e}, 32'd0);
    rd_reg(12'h030, r); chk("R3 ctrl unchanged", r, 32'd0);

    // R5 R7 R12 enable ordering, internal clock
    wr_reg(12'h004, 32'd100);
    wr_reg(12'h030, 32'h1);
    rd_reg(12'h000, r); chk("R5 count 1st read", r, 32'd0);
    rd_reg(12'h000, r); chk("R5 count 2nd read", r, 32'd0);
    rd_reg(12'h000, r); chk("R7 reload on first step", r, 32'd100);
    rd_reg(12'h000, r); chk("R12 count decrements", r, 32'd99);
    // R6 immediate stop
    wr_reg(12'h030, 32'h0);
    rd_reg(12'h000, r); chk("R6 count frozen", r, 32'd97);
    rd_reg(12'h000, r); chk("R6 count still frozen", r, 32'd97);
    // R8 count write gated by enable
    wr_reg(12'h000, 32'd55);
    rd_reg(12'h000, r); chk("R8 write ignored when off", r, 32'd97);
    wr_reg(12'h030, 32'h1);
    wr_reg(12'h000, 32'd40);
    rd_reg(12'h000, r); chk("R8 load when on", r, 32'd40);
    rd_reg(12'h000, r); chk("R8 counts on from load", r, 32'd39);
    wr_reg(12'h030, 32'h0);

    // R9 R10 table on channel 5 (window 0x60), external tick
    wr_reg(12'h064, 32'd50);
    wr_reg(12'h030, 32'h3 << 20);
    foreach (VECS[i]) begin
      wr_reg(12'h068, VECS[i].ma);
      wr_reg(12'h06C, VECS[i].mb);
      bus(1'b1, 12'h030, {8'd0, VECS[i].os, VECS[i].zie, 2'b11, 20'd0}, r, e);
      chk($sformatf("R11 upper one-shot no err row %0d", i), {31'd0, e}, 32'd0);
      wr_reg(12'h060, VECS[i].start);
      tick(5, iq);
      chk($sformatf("R9 irq row %0d", i), {31'd0, iq}, {31'd0, VECS[i].irq});
      rd_reg(12'h060, r);
      chk($sformatf("R10 count row %0d", i), r, VECS[i].cnt);
    end

    // R11 lower channel one-shot stored, flagged, ignored
    bus(1'b1, 12'h030, 32'h0000_00B0, r, e);
    chk("R11 lower one-shot err", {31'd0, e}, 32'd1);
    rd_reg(12'h030, r); chk("R11 bit stored", r, 32'h0000_00B0);
    wr_reg(12'h014, 32'd7);
    wr_reg(12'h010, 32'd0);
    tick(1, iq);
    chk("R11 no irq on reload", {31'd0, iq}, 32'd0);
    rd_reg(12'h010, r); chk("R11 lower reloads at zero", r, 32'd7);
    rd_reg(12'h010, r2); chk("R7 no step without tick", r2, 32'd7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule